// File: doc/BRIEF.md
# Amplifier Reset, Mute and Output-Enable Sequencer

This block sequences the output stage of a multichannel PWM audio amplifier. It reads four active-low controls (reset, power-down, soft mute, back-end error) and a headphone/speaker select. From them it derives a per-channel drive state, a master attenuation code, a VALID flag and the enables for the headphone and speaker paths. It also samples a strap pin at reset release to pick the control-bus address.

Reset clears every setting. Power-down stops all progress but keeps the settings. Back-end error forces a hard mute and leaves the settings alone. Soft mute ramps the attenuation toward silence. Unmuting ramps back to the programmed volume. The attenuation moves by one step each time a programmable number of sample ticks has passed. A new request reverses a ramp that is in progress from wherever it stands.

Reset is applied the moment it is asserted. Every other control, and the release of reset, passes through a two-flop synchroniser first.

Top module: `amp_seq_ctrl`

## Requirements
- R1: While `rst_ni` is low, `att_o` is 145, `valid_o` is 0, every `ch_state_o` field is 2'b00 and both enables are 0, from the instant of assertion. Reset also returns the programmed volume to 145.
- R2: After reset is released with power-down high, `valid_o` stays low for `INIT_CYCLES` clock cycles of initialisation. It then rises, and `att_o` is still 145 (mute).
- R3: While power-down is low, `valid_o` is 0, all channels are in hard mute, `att_o` holds its value and volume writes are ignored. When power-down is released, the earlier volume returns and VALID comes back without a new initialisation.
- R4: While back-end error is low, `valid_o` is 0 and all channels are in hard mute. The programmed volume is kept, and VALID returns within a few cycles of release.
- R5: While soft mute is low, `att_o` ramps to 145. It moves one code per `ramp_ticks_i` cycles with `tick_i` high; a value of 0 counts as 1. It does not move while `tick_i` is low.
- R6: When soft mute is released, `att_o` ramps back to the volume that was programmed before the mute.
- R7: A mute or unmute that arrives mid-ramp reverses the direction from the current `att_o` value.
- R8: With `hp_sel_i` low and VALID high, `hp_en_o`=1, `spk_en_o`=0 and the speaker channels are hard-muted. With `hp_sel_i` high, `spk_en_o`=1 and `hp_en_o`=0.
- R9: `addr_o` is the 7-bit address 7'h1A if `addr_sel_i` was 0 at reset release, and 7'h1B if it was 1. These are 0x34 and 0x36 in 8-bit write form.
- R10: With VALID high and speakers selected, each channel field reads 2'b10 (ramping) while `att_o` differs from its target, and 2'b01 (switching) once it matches.
- R11: VALID drops in the same cycle that any channel enters hard mute for reset, power-down or back-end error. Whenever VALID is low, all channel fields read 2'b00 and both enables are 0.
- R12: `att_o` code 0 is +18 dB, each code is 1 dB, and 145 is -127 dB (full attenuation). A written volume above 145 is clamped to 145.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pdn_ni | input | 1 | Power-down, active low |
| mute_ni | input | 1 | Soft mute, active low |
| bkerr_ni | input | 1 | Back-end error, active low |
| hp_sel_i | input | 1 | 0 selects headphone, 1 selects speakers |
| addr_sel_i | input | 1 | Address strap sampled at reset release |
| tick_i | input | 1 | Sample-rate tick |
| ramp_ticks_i | input | RT_W | Sample ticks per attenuation step |
| vol_we_i | input | 1 | Volume write strobe |
| vol_i | input | VOL_W | Volume code to write |
| att_o | output | VOL_W | Current master attenuation code |
| valid_o | output | 1 | Outputs valid |
| hp_en_o | output | 1 | Headphone path enable |
| spk_en_o | output | 1 | Speaker path enable |
| ch_state_o | output | 2*NUM_CH | Per-channel state: 00 hard mute, 01 switching, 10 ramping |
| addr_o | output | 7 | Latched control-bus address |

## Verification
The checker watches four properties on every cycle:
- `att_o` never moves by more than one code per cycle.
- The headphone and speaker enables are never both high.
- VALID low always means full hard mute, and VALID never rises before initialisation ends.
- Power-down freezes the attenuation, and the latched address never changes once taken.

Some behaviour can only be shown by the bench's scenarios:
- settings kept or cleared across reset, power-down and back-end error;
- a ramp returning to the pre-mute volume;
- reversal mid-ramp;
- the step rate;
- the clamp on written volumes.

// File: rtl/amp_seq_pkg.sv
`timescale 1ns/1ps
package amp_seq_pkg;
  typedef enum logic [1:0] {
    CH_HARD_MUTE = 2'b00,
    CH_SWITCH    = 2'b01,
    CH_RAMP      = 2'b10
  } ch_state_e;
endpackage

// File: rtl/amp_seq_sync.sv
`timescale 1ns/1ps
module amp_seq_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/amp_seq_init.sv
`timescale 1ns/1ps
module amp_seq_init #(
  parameter int INIT_CYCLES = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic done_o
);
  localparam int CW = $clog2(INIT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(INIT_CYCLES - 1);

  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else if (run_i && !done_q) begin
      if (cnt_q == LAST) done_q <= 1'b1;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/amp_seq_ramp.sv
`timescale 1ns/1ps
module amp_seq_ramp #(
  parameter int VOL_W   = 8,
  parameter int RT_W    = 8,
  parameter int ATT_MAX = 145
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             tick_i,
  input  logic [RT_W-1:0]  ramp_ticks_i,
  input  logic [VOL_W-1:0] target_i,
  output logic [VOL_W-1:0] att_o
);
  logic [VOL_W-1:0] att_q;
  logic [RT_W-1:0]  cnt_q;
  logic [RT_W:0]    eff_ticks, cnt_nxt;

  assign eff_ticks = (ramp_ticks_i == '0) ? (RT_W+1)'(1) : {1'b0, ramp_ticks_i};
  assign cnt_nxt   = {1'b0, cnt_q} + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      att_q <= VOL_W'(ATT_MAX);
      cnt_q <= '0;
    end else if (run_i && tick_i) begin
      if (att_q == target_i) begin
        cnt_q <= '0;
      end else if (cnt_nxt >= eff_ticks) begin
        cnt_q <= '0;
        // direction re-evaluated every step, so a new target reverses in place
        att_q <= (att_q < target_i) ? att_q + 1'b1 : att_q - 1'b1;
      end else begin
        cnt_q <= cnt_nxt[RT_W-1:0];
      end
    end
  end

  assign att_o = att_q;
endmodule

// File: rtl/amp_seq_ctrl.sv
`timescale 1ns/1ps
module amp_seq_ctrl
  import amp_seq_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int VOL_W       = 8,
  parameter int RT_W        = 8,
  parameter int ATT_MAX     = 145,
  parameter int INIT_CYCLES = 1000
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                pdn_ni,
  input  logic                mute_ni,
  input  logic                bkerr_ni,
  input  logic                hp_sel_i,
  input  logic                addr_sel_i,
  input  logic                tick_i,
  input  logic [RT_W-1:0]     ramp_ticks_i,
  input  logic                vol_we_i,
  input  logic [VOL_W-1:0]    vol_i,
  output logic [VOL_W-1:0]    att_o,
  output logic                valid_o,
  output logic                hp_en_o,
  output logic                spk_en_o,
  output logic [2*NUM_CH-1:0] ch_state_o,
  output logic [6:0]          addr_o
);
  localparam logic [VOL_W-1:0] ATT_FULL  = VOL_W'(ATT_MAX);
  localparam logic [5:0]       ADDR_BASE = 6'b001101;

  // release of reset is synchronised; assertion is immediate
  logic [1:0] rst_q;
  logic       live;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_q <= '0;
    else         rst_q <= {rst_q[0], 1'b1};
  end
  assign live = rst_q[1];

  logic [4:0] raw_in, sync_in;
  logic       pdn_s, mute_s, bk_s, hp_s, addr_s;
  assign raw_in = {addr_sel_i, hp_sel_i, bkerr_ni, mute_ni, pdn_ni};

  amp_seq_sync #(.W(5)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (raw_in),
    .q_o    (sync_in)
  );
  assign {addr_s, hp_s, bk_s, mute_s, pdn_s} = sync_in;

  logic run;
  assign run = live && pdn_s;

  logic init_done;
  amp_seq_init #(.INIT_CYCLES(INIT_CYCLES)) u_init (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .done_o (init_done)
  );

  logic [VOL_W-1:0] vol_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              vol_q <= ATT_FULL;
    else if (run && vol_we_i) vol_q <= (vol_i > ATT_FULL) ? ATT_FULL : vol_i;
  end

  logic addr_taken_q, addr_sel_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_taken_q <= 1'b0;
      addr_sel_q   <= 1'b0;
    end else if (live && !addr_taken_q) begin
      addr_taken_q <= 1'b1;
      addr_sel_q   <= addr_s;
    end
  end
  assign addr_o = {ADDR_BASE, addr_sel_q};

  logic [VOL_W-1:0] target, att;
  assign target = (init_done && mute_s) ? vol_q : ATT_FULL;

  amp_seq_ramp #(.VOL_W(VOL_W), .RT_W(RT_W), .ATT_MAX(ATT_MAX)) u_ramp (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .run_i        (run),
    .tick_i       (tick_i),
    .ramp_ticks_i (ramp_ticks_i),
    .target_i     (target),
    .att_o        (att)
  );

  logic valid;
  assign valid    = live && pdn_s && bk_s && init_done;
  assign valid_o  = valid;
  assign att_o    = att;
  assign hp_en_o  = valid && !hp_s;
  assign spk_en_o = valid && hp_s;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    ch_state_e st;
    always_comb begin
      if (!valid || !hp_s)  st = CH_HARD_MUTE;
      else if (att != target) st = CH_RAMP;
      else                  st = CH_SWITCH;
    end
    assign ch_state_o[2*g +: 2] = st;
  end
endmodule

// File: rtl/amp_seq_chk.sv
`timescale 1ns/1ps
module amp_seq_chk #(
  parameter int NUM_CH  = 8,
  parameter int VOL_W   = 8,
  parameter int ATT_MAX = 145
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic [VOL_W-1:0]    att_o,
  input logic                valid_o,
  input logic                hp_en_o,
  input logic                spk_en_o,
  input logic [2*NUM_CH-1:0] ch_state_o,
  input logic [6:0]          addr_o,
  input logic                init_done_i,
  input logic                pdn_s_i,
  input logic                taken_i
);
  // R5
  att_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (att_o != $past(att_o)) |->
      ((att_o == $past(att_o) + 1'b1) || (att_o + 1'b1 == $past(att_o))));

  // R8
  en_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hp_en_o && spk_en_o));

  // R11
  hard_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_o |-> (ch_state_o == '0 && !hp_en_o && !spk_en_o));

  // R2
  valid_init_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> init_done_i);

  // R2
  init_mute_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !init_done_i |-> att_o == VOL_W'(ATT_MAX));

  // R3
  pdn_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pdn_s_i |=> $stable(att_o));

  // R9
  addr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    taken_i |=> $stable(addr_o));

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni) rst_state_chk: assert (att_o == VOL_W'(ATT_MAX) && !valid_o);
  end
endmodule

bind amp_seq_ctrl amp_seq_chk #(
  .NUM_CH(NUM_CH), .VOL_W(VOL_W), .ATT_MAX(ATT_MAX)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .att_o       (att_o),
  .valid_o     (valid_o),
  .hp_en_o     (hp_en_o),
  .spk_en_o    (spk_en_o),
  .ch_state_o  (ch_state_o),
  .addr_o      (addr_o),
  .init_done_i (init_done),
  .pdn_s_i     (pdn_s),
  .taken_i     (addr_taken_q)
);

// File: tb/amp_seq_ctrl_tb.sv
`timescale 1ns/1ps
module amp_seq_ctrl_tb_top;
  localparam int NUM_CH = 8;
  localparam int VOL_W  = 8;
  localparam int RT_W   = 8;
  localparam int INIT   = 200;

  logic clk = 1'b0;
  logic rst_n = 1'b1, pdn_n = 1'b1, mute_n = 1'b1, bk_n = 1'b1;
  logic hp_sel = 1'b1, addr_sel = 1'b1, tick = 1'b1, we = 1'b0;
  logic [RT_W-1:0] rticks = 8'd1;
  logic [VOL_W-1:0] vol = '0;
  logic [VOL_W-1:0] att;
  logic valid, hp_en, spk_en;
  logic [2*NUM_CH-1:0] chs;
  logic [6:0] addr;

  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  amp_seq_ctrl #(.NUM_CH(NUM_CH), .VOL_W(VOL_W), .RT_W(RT_W), .INIT_CYCLES(INIT)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .pdn_ni(pdn_n), .mute_ni(mute_n), .bkerr_ni(bk_n),
    .hp_sel_i(hp_sel), .addr_sel_i(addr_sel), .tick_i(tick), .ramp_ticks_i(rticks),
    .vol_we_i(we), .vol_i(vol), .att_o(att), .valid_o(valid), .hp_en_o(hp_en),
    .spk_en_o(spk_en), .ch_state_o(chs), .addr_o(addr)
  );

  localparam logic [15:0] ALL_SW  = {NUM_CH{2'b01}};
  localparam logic [15:0] ALL_RMP = {NUM_CH{2'b10}};

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_vol(input int v);
    vol = VOL_W'(v); we = 1'b1; cyc(1); we = 1'b0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // {pdn_n, bkerr_n, hp_sel, exp_valid, exp_hp_en, exp_spk_en, exp_hard}
  localparam int NV = 6;
  localparam logic [6:0] VEC [NV] = '{
    7'b111_1010,
    7'b110_1101,
    7'b101_0001,
    7'b011_0001,
    7'b111_1010,
    7'b000_0001
  };

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  int a0, a1;
  initial begin
    #1 rst_n = 1'b0;
    cyc(2);
    // R1 reset state
    chk(att == 8'd145, "R1 att in reset", att, 145);
    chk(!valid && chs == '0 && !hp_en && !spk_en, "R1 hard mute in reset", {valid, chs}, 0);
    rst_n = 1'b1;
    cyc(50);
    chk(!valid, "R2 valid low during init", valid, 0);
    chk(addr == 7'h1B, "R9 address strap 1", addr, 'h1B);
    cyc(INIT);
    chk(valid, "R2 valid after init", valid, 1);
    chk(att == 8'd145, "R2 volume at mute after init", att, 145);

    // R3 R4 R8 R11 table
    for (int i = 0; i < NV; i++) begin
      pdn_n = VEC[i][6]; bk_n = VEC[i][5]; hp_sel = VEC[i][4];
      cyc(5);
      chk(valid == VEC[i][3], "R3/R4 table valid", valid, VEC[i][3]);
      chk(hp_en == VEC[i][2] && spk_en == VEC[i][1], "R8 table enables",
          {hp_en, spk_en}, {VEC[i][2], VEC[i][1]});
      chk(chs == (VEC[i][0] ? 16'h0 : ALL_SW), "R10/R11 table channel state",
          chs, VEC[i][0] ? 0 : ALL_SW);
    end
    pdn_n = 1'b1; bk_n = 1'b1; hp_sel = 1'b1;
    cyc(5);

    // R12 clamp
    wr_vol(200);
    cyc(80);
    chk(att == 8'd145, "R12 clamp above 145", att, 145);

    // R10 ramp state and R6
    rticks = 8'd2;
    wr_vol(120);
    cyc(5);
    chk(chs == ALL_RMP, "R10 ramping state", chs, ALL_RMP);
    cyc(100);
    chk(att == 8'd120, "R10 reached volume", att, 120);
    chk(chs == ALL_SW, "R10 switching when settled", chs, ALL_SW);
    mute_n = 1'b0;
    cyc(100);
    chk(att == 8'd145, "R5 soft mute to full attenuation", att, 145);
    mute_n = 1'b1;
    cyc(100);
    chk(att == 8'd120, "R6 unmute returns to prior volume", att, 120);

    // R5 rate: 4 ticks per step, ~40 cycles => ~10 steps
    rticks = 8'd4;
    mute_n = 1'b0;
    cyc(42);
    chk(att >= 8'd128 && att <= 8'd131, "R5 step rate", att, 130);
    // R7 reversal mid-ramp
    a0 = att;
    mute_n = 1'b1;
    cyc(30);
    chk(att < a0 && att > 8'd120, "R7 reversal from current value", att, a0 - 6);
    cyc(200);
    chk(att == 8'd120, "R7 reversal settles at volume", att, 120);

    // R5 ticks gate the ramp
    tick = 1'b0;
    mute_n = 1'b0;
    cyc(30);
    chk(att == 8'd120, "R5 no step without tick", att, 120);
    tick = 1'b1;
    mute_n = 1'b1;
    cyc(5);

    // R3 freeze and setting preservation
    rticks = 8'd1;
    mute_n = 1'b0;
    cyc(8);
    pdn_n = 1'b0;
    cyc(4);
    a1 = att;
    cyc(20);
    chk(att == a1 && a1 > 120 && a1 < 145, "R3 attenuation frozen in power-down", att, a1);
    wr_vol(50);
    pdn_n = 1'b1;
    mute_n = 1'b1;
    cyc(100);
    chk(valid, "R3 no re-init after power-down", valid, 1);
    chk(att == 8'd120, "R3 write ignored, volume kept", att, 120);

    // R4 back-end error keeps settings
    bk_n = 1'b0;
    cyc(5);
    chk(!valid && chs == '0, "R4 hard mute on back-end error", valid, 0);
    bk_n = 1'b1;
    cyc(5);
    chk(valid && att == 8'd120, "R4 settings kept after back-end error", att, 120);

    // R1 immediate asynchronous reset
    @(posedge clk); #1;
    rst_n = 1'b0;
    #0.5;
    chk(att == 8'd145 && !valid, "R1 immediate reset", att, 145);
    addr_sel = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(INIT + 20);
    chk(addr == 7'h1A, "R9 address strap 0", addr, 'h1A);
    chk(valid && att == 8'd145, "R1 volume default after reset", att, 145);
    finish_run();
  end
endmodule